// File: doc/BRIEF.md
# TDMA Slot Timing Generator

This block keeps the slot and symbol timing reference of a receiver that works on a 30 ms TDMA slot. The slot holds a 27.5 ms burst, centred with a 1.25 ms guard on each side. Inside the burst a 5.0 ms sync or signalling field sits between two payload fields of equal length. Time is counted in ticks, where each tick is one step of the fine timing resolution, and the block advances only on cycles where the tick enable is high. Until a sync detector reports a sync word, there is no timing, and every output stays quiet.

The first detect strobe, taken on a tick, locks the block. That tick is assigned a fixed position inside the slot, which is the constant offset between the detected sync and the internal reference at position 0. After lock the position counter runs freely and wraps once per slot, so slots that carry no sync are still framed. A later detect realigns the counter to the detected position.

From the position the block derives four outputs:
- a slot-start strobe;
- a burst window;
- four transmit event strobes, each placed by its own offset register. These offsets are counted in ticks from the internal reference, so they are tied to the received sync.

Top module: `tdma_slot_timer`

## Requirements
- R1: During and straight after reset, locked_o, slot_start_o, burst_win_o and evt_o are all 0.
- R2: While unlocked, ticks without sync_i produce no strobe and no window, and locked_o stays 0. A sync_i pulse in a cycle without tick_i is ignored.
- R3: A tick with sync_i high sets locked_o from the next clock on and gives that tick the slot position REF_OFFSET.
- R4: Once locked, locked_o stays high. Each tick without sync_i advances the position by one and wraps from SLOT_TICKS-1 to 0, with no further sync needed.
- R5: slot_start_o is high for exactly the one clock that follows the tick whose position is 0.
- R6: burst_win_o is high while locked and the current position p satisfies BURST_START <= p < BURST_START+BURST_LEN. It changes only in the clock after a tick.
- R7: evt_o[k] is high for the one clock that follows a tick whose position equals evt_off_i[k] (element k holds bits [k*CNT_W +: CNT_W]). An offset of SLOT_TICKS or more never fires.
- R8: A tick with sync_i high while already locked realigns the position to REF_OFFSET. Events and the window follow the new alignment from that tick on.
- R9: slot_start_o and evt_o are never high in a clock that does not directly follow a tick, so each strobe lasts one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timing resolution enable; one tick per fine time step |
| sync_i | input | 1 | Sync-detect strobe; effective only together with tick_i |
| evt_off_i | input | NUM_EVT*CNT_W | Event offsets in ticks from the internal reference, one field per event |
| locked_o | output | 1 | Slot timing established |
| slot_start_o | output | 1 | One-clock strobe at slot position 0 |
| burst_win_o | output | 1 | High while the position lies inside the burst |
| evt_o | output | NUM_EVT | One-clock transmit event strobes |

## Verification
If the internal position is off, the error first appears at the ports as a window edge or an event strobe on the wrong tick. If the position is off by one, the error is seen at the next event offset or window boundary, which comes within one slot. A broken wrap rule, or failing to reload on a realigning sync, shifts every later strobe. The bench therefore keeps a tick-by-tick model across several slots and compares every output on every clock. It also places offsets at 0, at the window boundaries, at the last position and beyond the slot.

// File: rtl/tdma_timing_pkg.sv
`timescale 1ns/1ps
package tdma_timing_pkg;
  // defaults at a 480-ticks-per-microsecond resolution
  localparam int unsigned SLOT_TICKS_DEF  = 14_400_000; // 30.0 ms
  localparam int unsigned BURST_START_DEF = 600_000;    // 1.25 ms guard
  localparam int unsigned BURST_LEN_DEF   = 13_200_000; // 27.5 ms
  localparam int unsigned REF_OFFSET_DEF  = 8_400_000;  // end of sync field
  localparam int unsigned NUM_EVT_DEF     = 4;
endpackage

// File: rtl/tdma_ref_counter.sv
`timescale 1ns/1ps
module tdma_ref_counter #(
  parameter int unsigned SLOT_TICKS = 600,
  parameter int unsigned REF_OFFSET = 350,
  parameter int unsigned CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             sync_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             locked_o,
  output logic             adv_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_TICKS - 1);
  localparam logic [CNT_W-1:0] REF  = CNT_W'(REF_OFFSET);

  logic lock_tick;
  assign lock_tick = tick_i & sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o    <= '0;
      locked_o <= 1'b0;
      adv_o    <= 1'b0;
    end else begin
      adv_o <= tick_i & (sync_i | locked_o);
      if (lock_tick) begin
        pos_o    <= REF;
        locked_o <= 1'b1;
      end else if (tick_i && locked_o) begin
        pos_o <= (pos_o == LAST) ? '0 : pos_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tdma_event_match.sv
`timescale 1ns/1ps
module tdma_event_match #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             adv_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             hit_o
);
  assign hit_o = adv_i & (pos_i == off_i);
endmodule

// File: rtl/tdma_burst_window.sv
`timescale 1ns/1ps
module tdma_burst_window #(
  parameter int unsigned CNT_W       = 10,
  parameter int unsigned BURST_START = 25,
  parameter int unsigned BURST_LEN   = 550
) (
  input  logic             locked_i,
  input  logic [CNT_W-1:0] pos_i,
  output logic             win_o
);
  localparam logic [CNT_W:0] LO = (CNT_W+1)'(BURST_START);
  localparam logic [CNT_W:0] HI = (CNT_W+1)'(BURST_START + BURST_LEN);

  logic [CNT_W:0] pos_ext;
  assign pos_ext = {1'b0, pos_i};
  assign win_o   = locked_i & (pos_ext >= LO) & (pos_ext < HI);
endmodule

// File: rtl/tdma_slot_timer.sv
`timescale 1ns/1ps
module tdma_slot_timer
  import tdma_timing_pkg::*;
#(
  parameter int unsigned SLOT_TICKS  = SLOT_TICKS_DEF,
  parameter int unsigned BURST_START = BURST_START_DEF,
  parameter int unsigned BURST_LEN   = BURST_LEN_DEF,
  parameter int unsigned REF_OFFSET  = REF_OFFSET_DEF,
  parameter int unsigned NUM_EVT     = NUM_EVT_DEF,
  localparam int unsigned CNT_W      = $clog2(SLOT_TICKS)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic                          sync_i,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] evt_off_i,
  output logic                          locked_o,
  output logic                          slot_start_o,
  output logic                          burst_win_o,
  output logic [NUM_EVT-1:0]            evt_o
);
  logic [CNT_W-1:0] pos;
  logic             adv;

  tdma_ref_counter #(
    .SLOT_TICKS(SLOT_TICKS),
    .REF_OFFSET(REF_OFFSET),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .sync_i  (sync_i),
    .pos_o   (pos),
    .locked_o(locked_o),
    .adv_o   (adv)
  );

  tdma_burst_window #(
    .CNT_W      (CNT_W),
    .BURST_START(BURST_START),
    .BURST_LEN  (BURST_LEN)
  ) u_win (
    .locked_i(locked_o),
    .pos_i   (pos),
    .win_o   (burst_win_o)
  );

  tdma_event_match #(.CNT_W(CNT_W)) u_start (
    .adv_i(adv),
    .pos_i(pos),
    .off_i('0),
    .hit_o(slot_start_o)
  );

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    tdma_event_match #(.CNT_W(CNT_W)) u_evt (
      .adv_i(adv),
      .pos_i(pos),
      .off_i(evt_off_i[k]),
      .hit_o(evt_o[k])
    );
  end
endmodule

// File: rtl/tdma_slot_timer_chk.sv
`timescale 1ns/1ps
module tdma_slot_timer_chk #(
  parameter int unsigned NUM_EVT = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               tick_i,
  input logic               sync_i,
  input logic               locked_o,
  input logic               slot_start_o,
  input logic               burst_win_o,
  input logic [NUM_EVT-1:0] evt_o
);
  AST_SYNC_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && sync_i) |=> locked_o); // R3

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o); // R4

  AST_QUIET_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> (!slot_start_o && !burst_win_o && evt_o == '0)); // R2

  AST_START_ONE_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_start_o |=> !slot_start_o); // R5

  AST_WIN_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(burst_win_o)); // R6

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_start_o || evt_o != '0) |-> $past(tick_i)); // R9
endmodule

bind tdma_slot_timer tdma_slot_timer_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .sync_i      (sync_i),
  .locked_o    (locked_o),
  .slot_start_o(slot_start_o),
  .burst_win_o (burst_win_o),
  .evt_o       (evt_o)
);

// File: tb/tb_tdma_slot_timer.sv
`timescale 1ns/1ps
module tb_tdma_slot_timer;
  localparam int SLOT = 600;
  localparam int BST  = 25;
  localparam int BLEN = 550;
  localparam int REFP = 350;
  localparam int NE   = 4;
  localparam int CW   = $clog2(SLOT);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic sync_i = 1'b0;
  logic [NE-1:0][CW-1:0] evt_off_i;
  logic locked_o, slot_start_o, burst_win_o;
  logic [NE-1:0] evt_o;

  always #2 clk_i = ~clk_i;

  tdma_slot_timer #(
    .SLOT_TICKS(SLOT), .BURST_START(BST), .BURST_LEN(BLEN),
    .REF_OFFSET(REFP), .NUM_EVT(NE)
  ) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sync_i(sync_i),
    .evt_off_i(evt_off_i), .locked_o(locked_o), .slot_start_o(slot_start_o),
    .burst_win_o(burst_win_o), .evt_o(evt_o)
  );

  typedef struct packed {
    logic          lk;
    logic          st;
    logic          win;
    logic [NE-1:0] ev;
  } exp_t;

  exp_t q[$];
  int n_tests = 0;
  int n_fail  = 0;
  string phase = "R2";
  bit done = 1'b0;

  int  m_pos = 0;
  bit  m_lk  = 1'b0;

  task automatic cmp(input logic [NE-1:0] act, input logic [NE-1:0] exp,
                     input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s/%s actual=%h expected=%h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // driver: applies one cycle of stimulus and predicts the outputs after the edge
  task automatic step(input bit t, input bit s);
    exp_t e;
    bit adv;
    @(negedge clk_i);
    tick_i = t;
    sync_i = s;
    adv = 1'b0;
    if (t && s) begin
      m_pos = REFP; m_lk = 1'b1; adv = 1'b1;
    end else if (t && m_lk) begin
      m_pos = (m_pos == SLOT-1) ? 0 : m_pos + 1; adv = 1'b1;
    end
    e.lk  = m_lk;
    e.st  = adv && (m_pos == 0);
    e.win = m_lk && (m_pos >= BST) && (m_pos < BST + BLEN);
    for (int k = 0; k < NE; k++) e.ev[k] = adv && (m_pos == int'(evt_off_i[k]));
    q.push_back(e);
  endtask

  // monitor
  always @(posedge clk_i) begin
    exp_t e;
    #1;
    if (rst_ni && q.size() > 0) begin
      e = q.pop_front();
      cmp(NE'(locked_o),     NE'(e.lk),  "R3");
      cmp(NE'(slot_start_o), NE'(e.st),  "R5");
      cmp(NE'(burst_win_o),  NE'(e.win), "R6");
      cmp(evt_o,             e.ev,       "R7");
    end
  end

  task automatic run(input int ticks, input int gap);
    for (int i = 0; i < ticks; i++) begin
      step(1'b1, 1'b0);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0);
    end
  endtask

  initial begin
    evt_off_i[0] = CW'(5);
    evt_off_i[1] = CW'(100);
    evt_off_i[2] = CW'(599);
    evt_off_i[3] = CW'(700); // beyond slot: never fires (R7)
    repeat (4) @(posedge clk_i);
    #1;
    // R1: reset state
    cmp(NE'(locked_o), '0, "R1");
    cmp(NE'(slot_start_o), '0, "R1");
    cmp(NE'(burst_win_o), '0, "R1");
    cmp(evt_o, '0, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    cmp({locked_o, slot_start_o, burst_win_o, 1'b0}, '0, "R1");
    // R2: unlocked ticks and a sync without tick do nothing
    phase = "R2";
    run(20, 1);
    step(1'b0, 1'b1);
    run(5, 0);
    // R3/R4: lock then free run through wraps, mixed tick spacing (R9)
    phase = "R4";
    step(1'b1, 1'b1);
    run(400, 1);
    run(500, 0);
    run(400, 2);
    // R8: realign mid-slot
    phase = "R8";
    step(1'b1, 1'b1);
    run(700, 1);
    // boundaries: offset 0, window edges, offset equal to REF at the sync tick
    phase = "R7";
    @(negedge clk_i);
    evt_off_i[0] = CW'(350);
    evt_off_i[1] = CW'(574);
    evt_off_i[2] = CW'(25);
    evt_off_i[3] = CW'(0);
    step(1'b1, 1'b1);
    run(650, 1);
    run(3, 0);
    @(posedge clk_i);
    #2;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R4 actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule